// File: doc/BRIEF.md
# Windowed Multi-Channel Sample Framer

This block gathers per-step samples from several measurement channels into fixed-size frames, so that a host running far slower than the sampling logic can collect a whole window of samples in one transaction instead of one per step. Each channel owns a shift chain whose taps are all visible at once. A sample strobe pushes one new value per channel into its chain. A window counter counts those strobes, and when a full window has been gathered the complete set of taps is copied in parallel into a holding register. That register is then offered to the host side with a valid/ready handshake.

The default window is 100 samples for each of two channels: channel 0 carries the output current and channel 1 the output voltage of the simulated plant. The window depth is a parameter. An elaboration-time check keeps it between a lower bound, below which the host would be flooded with transactions, and an upper bound set by the largest payload one transaction can carry. Consecutive frames hold back-to-back, non-overlapping windows. If the host has not taken a frame by the time the next window completes, that window is discarded and a sticky overflow flag records the loss.

The reset input is asserted asynchronously. Its release is synchronised inside the block with two flops, so the block leaves reset on the second rising clock edge after `rst_n` goes high.

Top module: `smp_frame_capture`

## Requirements
- R1: While reset is applied, and right after it is released, `frm_valid` and `frm_ovf` are 0. Only a reset clears `frm_ovf`.
- R2: A channel's chain advances only on a cycle with `smp_stb` high. Idle cycles between strobes leave no gap and no duplicate in the captured window.
- R3: After reset no frame is offered until exactly DEPTH strobes have been received. `frm_valid` rises in the cycle after the clock edge that sampled the DEPTH-th strobe.
- R4: Frame layout: input channel c is read from `smp_data[c*SAMPLE_W +: SAMPLE_W]`. Sample i of channel c appears at `frm_data[(c*DEPTH+i)*SAMPLE_W +: SAMPLE_W]`, with i = 0 the oldest sample of the window. Channel 0 is the output current and channel 1 the output voltage.
- R5: The window counter wraps on the same strobe that fires a capture. Frame k (counted from 0 since reset) therefore holds strobes k*DEPTH to k*DEPTH+DEPTH-1.
- R6: While `frm_valid` is 1 and `frm_ready` is 0, `frm_valid` stays 1 and `frm_data` does not change.
- R7: A cycle with `frm_valid` and `frm_ready` both 1 accepts the frame. Unless a new capture fires in that same cycle, `frm_valid` is 0 after that clock edge.
- R8: A capture that fires while a frame is pending and not being accepted is dropped: `frm_data` keeps the pending frame and `frm_ovf` becomes 1 and stays 1. The counter still wraps, so the next frame holds the window that follows the dropped one.
- R9: A capture that fires in the same cycle as an acceptance loads the new window, and `frm_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside the block |
| smp_stb | input | 1 | One new sample per channel is present this cycle |
| smp_data | input | NUM_CH*SAMPLE_W | Channel samples, channel c in bits [c*SAMPLE_W +: SAMPLE_W] |
| frm_ready | input | 1 | Host side takes the offered frame |
| frm_valid | output | 1 | A captured frame is offered |
| frm_data | output | NUM_CH*DEPTH*SAMPLE_W | Captured window, laid out as in R4 |
| frm_ovf | output | 1 | Sticky flag: at least one window was dropped |

## Verification
The assertions watch, on every cycle, the properties that need only a few cycles of history. They check that a pending frame keeps its valid and its data until it is accepted, that the overflow flag never falls and only rises while a frame is pending, that the chains and the counter stand still without a strobe, that the counter stays in range and wraps after a capture, and that a frame appears only after a strobe. Only the bench scenarios can show the content of the frames. The bench checks the oldest-first layout for each channel, the exact strobe on which the first frame appears, the back-to-back windows across frames, the window that follows a dropped one, and a capture that coincides with an acceptance.

// File: rtl/smp_cap_pkg.sv
package smp_cap_pkg;

  // Action taken by the frame holding stage in one cycle
  typedef enum logic [1:0] {
    HOLD_KEEP    = 2'd0,
    HOLD_LOAD    = 2'd1,
    HOLD_DROP    = 2'd2,
    HOLD_RELEASE = 2'd3
  } hold_act_e;

  // Lowest bit of channel ch, sample idx inside a flat frame
  function automatic int frame_lsb(int ch, int idx, int depth, int width);
    return (ch * depth + idx) * width;
  endfunction

endpackage

// File: rtl/cap_delay_line.sv
module cap_delay_line #(
  parameter int DEPTH    = 100,
  parameter int SAMPLE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      shift_en,
  input  logic [SAMPLE_W-1:0]       din,
  output logic [DEPTH*SAMPLE_W-1:0] win_next_o
);

  localparam int LAST = DEPTH - 1;

  logic [SAMPLE_W-1:0] tap_q [DEPTH];
  logic [SAMPLE_W-1:0] tap_d [DEPTH];

  // Next state: tap 0 is the oldest, new samples enter at the last tap
  for (genvar k = 0; k < DEPTH; k++) begin : g_tap
    if (k == LAST) begin : g_head
      always_comb begin
        tap_d[k] = shift_en ? din : tap_q[k];
      end
    end else begin : g_body
      always_comb begin
        tap_d[k] = shift_en ? tap_q[k+1] : tap_q[k];
      end
    end
    assign win_next_o[k*SAMPLE_W +: SAMPLE_W] = tap_d[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) tap_q[k] <= '0;
    end else if (shift_en) begin
      for (int k = 0; k < DEPTH; k++) tap_q[k] <= tap_d[k];
    end
  end

  AST_TAPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> (tap_q[0] == $past(tap_q[0])) && (tap_q[LAST] == $past(tap_q[LAST]))); // R2

  AST_TAPS_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> tap_q[LAST] == $past(din)); // R2

endmodule

// File: rtl/cap_window_ctr.sv
module cap_window_ctr #(
  parameter int DEPTH = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  output logic fire_o
);

  localparam int CNT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  always_comb begin
    at_last = (cnt_q == CNT_LAST);
    fire_o  = step_en && at_last;
    cnt_d   = cnt_q;
    if (step_en) begin
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (step_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_LAST); // R5

  AST_WRAP_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> cnt_q == '0); // R5

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/cap_frame_hold.sv
module cap_frame_hold
  import smp_cap_pkg::*;
#(
  parameter int FRAME_W = 3200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_req,
  input  logic [FRAME_W-1:0] win_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [FRAME_W-1:0] data_o,
  output logic               ovf_o
);

  hold_act_e    act;
  logic         accept;
  logic         valid_d;
  logic         ovf_d;
  logic         data_en;

  always_comb begin
    accept = valid_o && ready_i;
    if (load_req && (!valid_o || accept)) begin
      act = HOLD_LOAD;
    end else if (load_req) begin
      act = HOLD_DROP;
    end else if (accept) begin
      act = HOLD_RELEASE;
    end else begin
      act = HOLD_KEEP;
    end

    valid_d = valid_o;
    ovf_d   = ovf_o;
    data_en = 1'b0;
    unique case (act)
      HOLD_LOAD:    begin valid_d = 1'b1; data_en = 1'b1; end
      HOLD_DROP:    ovf_d   = 1'b1;
      HOLD_RELEASE: valid_d = 1'b0;
      default:      ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_d;
      ovf_o   <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
    end else if (data_en) begin
      data_o <= win_i;
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o); // R6

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> $stable(data_o)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o); // R8

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(valid_o) && !$past(ready_i)); // R8

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && !load_req |=> !valid_o); // R7

  AST_LOAD_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && load_req |=> valid_o); // R9

endmodule

// File: rtl/smp_frame_capture.sv
module smp_frame_capture #(
  parameter int NUM_CH    = 2,
  parameter int SAMPLE_W  = 16,
  parameter int DEPTH     = 100,
  parameter int MIN_DEPTH = 8,
  parameter int MAX_DEPTH = 256
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             smp_stb,
  input  logic [NUM_CH*SAMPLE_W-1:0]       smp_data,
  input  logic                             frm_ready,
  output logic                             frm_valid,
  output logic [NUM_CH*DEPTH*SAMPLE_W-1:0] frm_data,
  output logic                             frm_ovf
);

  import smp_cap_pkg::*;

  localparam int CH_W    = DEPTH * SAMPLE_W;
  localparam int FRAME_W = NUM_CH * CH_W;

  if ((DEPTH < MIN_DEPTH) || (DEPTH > MAX_DEPTH) || (DEPTH < 2)) begin : g_bad_depth
    $error("smp_frame_capture: DEPTH out of the allowed range");
  end

  // Reset: asserted at once, released on the second clock edge
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [FRAME_W-1:0] window;
  logic               capture_due;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cap_delay_line #(
      .DEPTH    (DEPTH),
      .SAMPLE_W (SAMPLE_W)
    ) u_line (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .shift_en   (smp_stb),
      .din        (smp_data[c*SAMPLE_W +: SAMPLE_W]),
      .win_next_o (window[frame_lsb(c, 0, DEPTH, SAMPLE_W) +: CH_W])
    );
  end

  cap_window_ctr #(
    .DEPTH (DEPTH)
  ) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_en (smp_stb),
    .fire_o  (capture_due)
  );

  cap_frame_hold #(
    .FRAME_W (FRAME_W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_req (capture_due),
    .win_i    (window),
    .ready_i  (frm_ready),
    .valid_o  (frm_valid),
    .data_o   (frm_data),
    .ovf_o    (frm_ovf)
  );

  AST_FRAME_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(frm_valid) |-> $past(smp_stb)); // R3

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_sync_n |-> !frm_valid && !frm_ovf); // R1

endmodule

// File: tb/smp_frame_capture_tb_top.sv
module smp_frame_capture_tb_top;

  localparam int CLK_PERIOD_NS = 10;
  localparam int NUM_CH   = 2;
  localparam int SAMPLE_W = 16;
  localparam int DEPTH    = 100;

  logic                             clk;
  logic                             rst_n;
  logic                             smp_stb;
  logic [NUM_CH*SAMPLE_W-1:0]       smp_data;
  logic                             frm_ready;
  logic                             frm_valid;
  logic [NUM_CH*DEPTH*SAMPLE_W-1:0] frm_data;
  logic                             frm_ovf;

  int checks;
  int fails;
  int sn;
  bit done;

  smp_frame_capture #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W),
    .DEPTH    (DEPTH)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_stb   (smp_stb),
    .smp_data  (smp_data),
    .frm_ready (frm_ready),
    .frm_valid (frm_valid),
    .frm_data  (frm_data),
    .frm_ovf   (frm_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD_NS/2) clk = ~clk;

  // Sample value of channel c for strobe number n
  function automatic logic [SAMPLE_W-1:0] sval(int c, int n);
    return (c == 0) ? SAMPLE_W'(n) : SAMPLE_W'(32'hA000 + n);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_frame(int base, string req);
    int bad_c = -1, bad_i = -1, act = 0, exp = 0;
    for (int c = 0; c < NUM_CH; c++) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (bad_c < 0 && frm_data[(c*DEPTH+i)*SAMPLE_W +: SAMPLE_W] !== sval(c, base + i)) begin
          bad_c = c; bad_i = i;
          act = int'(frm_data[(c*DEPTH+i)*SAMPLE_W +: SAMPLE_W]);
          exp = int'(sval(c, base + i));
        end
      end
    end
    chk(bad_c < 0, req, $sformatf("frame base %0d ch %0d idx %0d", base, bad_c, bad_i), act, exp);
  endtask

  task automatic strobe(bit rdy);
    @(negedge clk);
    smp_stb   = 1'b1;
    smp_data  = {sval(1, sn), sval(0, sn)};
    frm_ready = rdy;
    @(negedge clk);
    smp_stb   = 1'b0;
    frm_ready = 1'b0;
    sn++;
  endtask

  task automatic accept_frame(string req);
    @(negedge clk);
    frm_ready = 1'b1;
    @(negedge clk);
    frm_ready = 1'b0;
    chk(frm_valid == 1'b0, req, "valid after accept", int'(frm_valid), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    smp_stb = 1'b0;
    frm_ready = 1'b0;
    smp_data = '0;
    sn = 0;
    repeat (3) @(negedge clk);
    chk(frm_valid == 1'b0, "R1", "valid in reset", int'(frm_valid), 0);
    chk(frm_ovf == 1'b0, "R1", "ovf in reset", int'(frm_ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(frm_valid == 1'b0, "R1", "valid after reset", int'(frm_valid), 0);
    chk(frm_ovf == 1'b0, "R1", "ovf after reset", int'(frm_ovf), 0);
  endtask

  task automatic t_first_frame();
    for (int k = 0; k < DEPTH - 1; k++) begin
      strobe(1'b0);
      if (k % 7 == 0) repeat (2) @(negedge clk);
    end
    chk(frm_valid == 1'b0, "R3", "valid before last strobe", int'(frm_valid), 0);
    strobe(1'b0);
    chk(frm_valid == 1'b1, "R3", "valid after DEPTH strobes", int'(frm_valid), 1);
    chk_frame(0, "R4");
    chk_frame(0, "R2");
    chk(frm_ovf == 1'b0, "R8", "ovf without drop", int'(frm_ovf), 0);
  endtask

  task automatic t_hold_accept();
    repeat (5) @(negedge clk);
    chk(frm_valid == 1'b1, "R6", "valid while not ready", int'(frm_valid), 1);
    chk_frame(0, "R6");
    accept_frame("R7");
  endtask

  task automatic t_contiguous();
    for (int k = 0; k < DEPTH; k++) begin
      strobe(1'b0);
      if (k % 11 == 3) @(negedge clk);
    end
    chk(frm_valid == 1'b1, "R5", "second frame valid", int'(frm_valid), 1);
    chk_frame(DEPTH, "R5");
  endtask

  task automatic t_overflow();
    for (int k = 0; k < DEPTH; k++) strobe(1'b0);
    chk(frm_valid == 1'b1, "R8", "valid kept on drop", int'(frm_valid), 1);
    chk_frame(DEPTH, "R8");
    chk(frm_ovf == 1'b1, "R8", "ovf after drop", int'(frm_ovf), 1);
    accept_frame("R7");
    for (int k = 0; k < DEPTH; k++) strobe(1'b0);
    chk(frm_valid == 1'b1, "R8", "frame after drop valid", int'(frm_valid), 1);
    chk_frame(3 * DEPTH, "R8");
    chk(frm_ovf == 1'b1, "R8", "ovf sticky", int'(frm_ovf), 1);
  endtask

  task automatic t_same_cycle();
    for (int k = 0; k < DEPTH - 1; k++) strobe(1'b0);
    chk_frame(3 * DEPTH, "R6");
    strobe(1'b1);
    chk(frm_valid == 1'b1, "R9", "valid on accept+capture", int'(frm_valid), 1);
    chk_frame(4 * DEPTH, "R9");
    accept_frame("R7");
  endtask

  task automatic t_reset_clears();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(frm_ovf == 1'b0, "R1", "ovf cleared by reset", int'(frm_ovf), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    done   = 1'b0;
    t_reset();
    t_first_frame();
    t_hold_accept();
    t_contiguous();
    t_overflow();
    t_same_cycle();
    t_reset_clears();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule